// File: doc/BRIEF.md
# XGMII Link Fault Monitor

This block sits between a 10 Gb/s MAC and the physical coding sublayer on a 32-bit, single-data-rate XGMII. Each column holds four byte lanes and four control bits. On the receive side it looks for fault ordered sets and keeps a three-valued link status: OK, Local Fault or Remote Fault. A status is entered after four matching fault messages fall inside a 128-column window. The status falls back to OK after 128 columns with no fault message.

On the transmit side the block sits in the client's outgoing path and registers every column once. While the link is OK, client columns pass through unchanged. While in Local Fault, it sends the remote fault ordered set in every column so that the far end learns of the problem. While in Remote Fault, it sends idle columns. The override starts on the first column after the status changes, even in the middle of a frame.

Top module: `xgmii_fault_mon`

## Requirements
- R1: During and right after reset, `link_state` is 2'b00 (OK), and the transmit output is the idle column: data 32'h07070707 with control 4'hF.
- R2: A column is a fault message only when control is exactly 4'b0001, byte 0 is 8'h9C, bytes 1 and 2 are 8'h00, and byte 3 is 8'h01 (local) or 8'h02 (remote). Columns that differ in any control bit or byte are not counted.
- R3: Four local fault messages whose first and last columns are at most 127 columns apart set `link_state` to 2'b01 (Local Fault) on the clock edge that samples the fourth one.
- R4: Four remote fault messages under the same window rule set `link_state` to 2'b10 (Remote Fault).
- R5: A fourth message exactly 127 columns after the first of its run completes the run. A message 128 or more columns after the first starts a new run, and that message counts as its first.
- R6: A fault message of the other type than the run being counted starts a new run of its own type.
- R7: After 128 consecutive columns with no fault message, `link_state` returns to 2'b00. After 127 such columns, it does not.
- R8: While `link_state` is OK, the transmit output equals the client column from one clock earlier, both data and control.
- R9: While `link_state` is Local Fault, every transmit column one clock later is the remote fault ordered set: data 32'h0200009C with control 4'b0001.
- R10: While `link_state` is Remote Fault, every transmit column one clock later is the idle column: 32'h07070707 with control 4'hF.
- R11: The forced transmit columns replace client packet bytes starting with the first column after the status change. The block does not wait for a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 32 | Receive column data, byte lane i in bits 8i+7:8i |
| rx_ctrl | input | 4 | Receive control bits, bit i qualifies byte lane i |
| tx_in_data | input | 32 | Client transmit column data |
| tx_in_ctrl | input | 4 | Client transmit control bits |
| tx_out_data | output | 32 | Registered transmit column data |
| tx_out_ctrl | output | 4 | Registered transmit control bits |
| link_state | output | 2 | 00 OK, 01 Local Fault, 10 Remote Fault |

## Verification
A wrong run count or window age shows up at `link_state` on the exact column where a fourth message should or should not complete a run. The bench therefore places messages at offsets 127 and 128 from the first of a run and mixes the two message types. A stale quiet counter shows up as a status that drops one column early or late, so the 127th and 128th quiet columns are checked. Because the transmit mux follows the status register, any status error reaches `tx_out_data` one column later. Comparing against a behavioural model on every clock catches it within two columns.

// File: rtl/xgmii_fault_mon.sv
module xgmii_fault_mon #(
  parameter int WINDOW = 128,
  parameter int THRESH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rx_data,
  input  logic [3:0]  rx_ctrl,
  input  logic [31:0] tx_in_data,
  input  logic [3:0]  tx_in_ctrl,
  output logic [31:0] tx_out_data,
  output logic [3:0]  tx_out_ctrl,
  output logic [1:0]  link_state
);

  localparam int AW = $clog2(WINDOW + 1);
  localparam int NW = $clog2(THRESH + 1);
  localparam logic [1:0]  ST_OK     = 2'b00;
  localparam logic [1:0]  ST_LOCAL  = 2'b01;
  localparam logic [1:0]  ST_REMOTE = 2'b10;
  localparam logic [31:0] IDLE_D    = 32'h07070707;
  localparam logic [31:0] RFLT_D    = 32'h0200009C;

  logic [NW-1:0] hits;
  logic          hit_rf;
  logic [AW-1:0] age;
  logic [AW-1:0] quiet;
  logic [1:0]    state;

  wire seq_col = (rx_ctrl == 4'b0001) && (rx_data[23:0] == 24'h00009C);
  wire lf_msg  = seq_col && (rx_data[31:24] == 8'h01);
  wire rf_msg  = seq_col && (rx_data[31:24] == 8'h02);
  wire msg     = lf_msg || rf_msg;

  wire fresh = (hits == '0) || (hit_rf != rf_msg) || (age >= AW'(WINDOW));
  wire full  = !fresh && (hits == NW'(THRESH - 1));

  assign link_state = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hits   <= '0;
      hit_rf <= 1'b0;
      age    <= '0;
      quiet  <= '0;
      state  <= ST_OK;
    end else if (msg) begin
      quiet <= '0;
      if (fresh) begin
        hits   <= NW'(1);
        hit_rf <= rf_msg;
        age    <= AW'(1);
      end else if (full) begin
        hits  <= '0;
        state <= rf_msg ? ST_REMOTE : ST_LOCAL;
      end else begin
        hits <= hits + 1'b1;
        if (age < AW'(WINDOW)) age <= age + 1'b1;
      end
    end else begin
      if (hits != '0 && age < AW'(WINDOW)) age <= age + 1'b1;
      if (quiet == AW'(WINDOW - 1)) state <= ST_OK;
      else quiet <= quiet + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out_data <= IDLE_D;
      tx_out_ctrl <= 4'hF;
    end else begin
      case (state)
        ST_LOCAL: begin
          tx_out_data <= RFLT_D;
          tx_out_ctrl <= 4'b0001;
        end
        ST_REMOTE: begin
          tx_out_data <= IDLE_D;
          tx_out_ctrl <= 4'hF;
        end
        default: begin
          tx_out_data <= tx_in_data;
          tx_out_ctrl <= tx_in_ctrl;
        end
      endcase
    end
  end

  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_OK |=> tx_out_data == $past(tx_in_data) && tx_out_ctrl == $past(tx_in_ctrl));

  // R9
  local_sends_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LOCAL |=> tx_out_data == RFLT_D && tx_out_ctrl == 4'b0001);

  // R10
  remote_sends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_REMOTE |=> tx_out_data == IDLE_D && tx_out_ctrl == 4'hF);

  // R3
  fault_entry_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_OK && state != $past(state)) |-> $past(msg));

  // R7
  no_clear_on_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_OK && msg) |=> state != ST_OK);

endmodule

// File: tb/xgmii_fault_mon_tb.sv
module xgmii_fault_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_data = 32'h07070707;
  logic [3:0]  rx_ctrl = 4'hF;
  logic [31:0] tx_in_data = 32'h0;
  logic [3:0]  tx_in_ctrl = 4'h0;
  logic [31:0] tx_out_data;
  logic [3:0]  tx_out_ctrl;
  logic [1:0]  link_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int n = 0;

  // reference model state
  int q[$];
  int qt = 0;
  int col = 0;
  int run = 0;
  int mstat = 0;
  logic [31:0] exp_d = 32'h07070707;
  logic [3:0]  exp_c = 4'hF;
  int exp_src = 0;

  always #4 clk = ~clk;

  xgmii_fault_mon u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .tx_in_data(tx_in_data), .tx_in_ctrl(tx_in_ctrl),
    .tx_out_data(tx_out_data), .tx_out_ctrl(tx_out_ctrl), .link_state(link_state)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); qt = 0; col = 0; run = 0; mstat = 0;
      exp_d = 32'h07070707; exp_c = 4'hF; exp_src = 0;
    end else begin
      int t;
      exp_src = mstat;
      if (mstat == 1) begin exp_d = 32'h0200009C; exp_c = 4'h1; end
      else if (mstat == 2) begin exp_d = 32'h07070707; exp_c = 4'hF; end
      else begin exp_d = tx_in_data; exp_c = tx_in_ctrl; end
      t = 0;
      if (rx_ctrl == 4'h1 && rx_data == {8'h01, 8'h00, 8'h00, 8'h9C}) t = 1;
      if (rx_ctrl == 4'h1 && rx_data == {8'h02, 8'h00, 8'h00, 8'h9C}) t = 2;
      if (t != 0) begin
        run = 0;
        if (q.size() == 0 || qt != t || col - q[0] >= 128) begin
          q.delete(); q.push_back(col); qt = t;
        end else begin
          q.push_back(col);
          if (q.size() == 4) begin mstat = t; q.delete(); end
        end
      end else begin
        run++;
        if (run >= 128) mstat = 0;
      end
      col++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(link_state == 2'(mstat), "R3/R4/R7 status vs model", {34'd0, link_state}, 36'(mstat));
      if (exp_src == 1)
        chk({tx_out_ctrl, tx_out_data} == {exp_c, exp_d}, "R9 tx vs model", {tx_out_ctrl, tx_out_data}, {exp_c, exp_d});
      else if (exp_src == 2)
        chk({tx_out_ctrl, tx_out_data} == {exp_c, exp_d}, "R10 tx vs model", {tx_out_ctrl, tx_out_data}, {exp_c, exp_d});
      else
        chk({tx_out_ctrl, tx_out_data} == {exp_c, exp_d}, "R8 tx vs model", {tx_out_ctrl, tx_out_data}, {exp_c, exp_d});
    end
  end

  task automatic step(input logic [31:0] d, input logic [3:0] c);
    @(negedge clk);
    rx_data = d;
    rx_ctrl = c;
    n++;
    tx_in_data = {n[7:0], 8'h5A, n[15:8], ~n[7:0]};
    tx_in_ctrl = 4'h0;
    @(posedge clk);
    #1;
  endtask

  task automatic lf(); step(32'h0100009C, 4'h1); endtask
  task automatic rf(); step(32'h0200009C, 4'h1); endtask
  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(32'h07070707, 4'hF);
  endtask

  task automatic st(input logic [1:0] e, input string tag);
    chk(link_state == e, tag, {34'd0, link_state}, {34'd0, e});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    st(2'b00, "R1 reset status");
    chk({tx_out_ctrl, tx_out_data} == {4'hF, 32'h07070707}, "R1 reset tx", {tx_out_ctrl, tx_out_data}, {4'hF, 32'h07070707});
    @(negedge clk);
    rst_n = 1'b1;

    // R2 near-miss columns never count
    for (int i = 0; i < 6; i++) step(32'h0100009C, 4'h3);
    for (int i = 0; i < 6; i++) step(32'h0100019C, 4'h1);
    st(2'b00, "R2 near-miss ignored");

    // R3 four local messages at offsets 0,40,80,120
    for (int k = 0; k < 3; k++) begin lf(); idle(39); end
    lf();
    st(2'b01, "R3 local fault set");
    step(32'h07070707, 4'hF);
    chk({tx_out_ctrl, tx_out_data} == {4'h1, 32'h0200009C}, "R11 override mid-packet", {tx_out_ctrl, tx_out_data}, {4'h1, 32'h0200009C});
    idle(126);
    st(2'b01, "R7 still faulted after 127 quiet");
    idle(1);
    st(2'b00, "R7 cleared after 128 quiet");

    // R5 fourth remote at offset 127 completes
    rf(); rf(); rf(); idle(124); rf();
    st(2'b10, "R5 offset 127 completes, R4 remote set");
    step(32'h07070707, 4'hF);
    chk({tx_out_ctrl, tx_out_data} == {4'hF, 32'h07070707}, "R10 idle forced", {tx_out_ctrl, tx_out_data}, {4'hF, 32'h07070707});
    idle(128);
    st(2'b00, "R7 cleared");
    begin
      logic [35:0] sent;
      step(32'h07070707, 4'hF);
      sent = {tx_in_ctrl, tx_in_data};
      chk({tx_out_ctrl, tx_out_data} == sent, "R8 pass-through", {tx_out_ctrl, tx_out_data}, sent);
    end

    // R5 offset 128 restarts the run
    lf(); lf(); lf(); idle(125); lf();
    st(2'b00, "R5 offset 128 not counted");
    lf(); lf(); lf();
    st(2'b01, "R5 restarted run completes");
    idle(128);
    st(2'b00, "R7 cleared");

    // R6 type change restarts
    lf(); lf(); lf(); rf(); rf(); rf();
    st(2'b00, "R6 mixed types not set");
    rf();
    st(2'b10, "R6 new remote run completes");
    idle(200);
    st(2'b00, "R7 final clear");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule